// File: doc/BRIEF.md
# Data Pointer Address Generation Unit

This block forms the effective data-space address for every load and store in a small 8-bit microcontroller core. Three 16-bit pointers (X, Y and Z) are assembled from six byte registers of the register file. A 3-bit mode code selects one of five ways of producing the address: a direct 16-bit operand, the pointer itself, the pointer plus an unsigned 6-bit offset, the pointer after a decrement, or the pointer with an increment afterwards.

The two modes that modify a pointer also present the new pointer value, the pointer index and a write-back strobe, which the register file uses to store the value back. All arithmetic is combinational. It is captured in one output register at the end of the address-compute cycle, so every result appears on the clock edge that follows the request. A request that cannot be served raises an illegal flag in place of an address. Such requests are a displacement on X, an unknown pointer index in a pointer mode, or a reserved mode code.

Top module: `data_ptr_agu`

## Requirements
- R1: While reset is asserted and after it is released with no request, `ea`, `ea_valid`, `wb_en`, `wb_sel`, `wb_value` and `illegal` are all zero.
- R2: Mode code 0 (direct) returns `direct_addr` unchanged on `ea` for any 16-bit value, ignores `ptr_sel` and gives no write-back.
- R3: Mode code 1 (indirect) returns the selected pointer on `ea` with no write-back. `ptr_sel` 0, 1 and 2 pick X, Y and Z. `ptr_bytes` holds R26 in bits 7:0 up to R31 in bits 47:40. X is R27:R26, Y is R29:R28 and Z is R31:R30, and the lower-numbered register of each pair is the low byte.
- R4: Mode code 2 (displacement) with Y or Z returns the pointer plus `disp` zero-extended (0 to 63), with no write-back.
- R5: Mode code 2 with X selected sets `illegal`, clears `ea_valid`, and gives `ea` of zero with no write-back.
- R6: Mode code 3 (pre-decrement) returns the pointer minus one on `ea`. It also asserts `wb_en` with `wb_value` equal to that same address and `wb_sel` equal to `ptr_sel`.
- R7: Mode code 4 (post-increment) returns the unmodified pointer on `ea`. It also asserts `wb_en` with `wb_value` equal to the pointer plus one and `wb_sel` equal to `ptr_sel`.
- R8: All pointer arithmetic wraps modulo 2^16. For example, 0x0000 decremented gives 0xFFFF, 0xFFFF incremented gives 0x0000, and 0xFFC1 plus 63 gives 0x0000.
- R9: The outputs for a request appear after the next rising clock edge. A cycle without `req_valid` leaves all outputs zero after the following edge. When `wb_en` is low, `wb_sel` and `wb_value` read zero.
- R10: Mode codes 5 to 7, and `ptr_sel` 3 in any pointer mode, set `illegal` with `ea_valid`, `wb_en` and `ea` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An address request is present this cycle |
| mode | input | 3 | Addressing mode code (0 to 4 legal) |
| ptr_sel | input | 2 | Pointer index: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct address operand |
| ptr_bytes | input | 48 | Register-file bytes R26..R31, R26 in the low byte |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | `ea` holds a legal result |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | New pointer value |
| illegal | output | 1 | The request was not a legal combination |

## Verification
Every mode code 0 to 7 is crossed with all four pointer indices and six pointer values. Three of those values sit at the wrap points (0x0000, 0xFFFF, 0xFFC1), and each combination is tried with displacements of 0, 1, 62 and 63. The three pointers carry different values built from their bytes, so a wrong pair order, a swapped byte or a wrong index shows up as a wrong address. The wrap-point values separate modulo arithmetic from saturating or sign-handling errors. The X/displacement cases and the reserved codes separate the illegal path from the legal ones, and idle cycles between bursts show that no output is held over.

// File: rtl/agu_pkg.sv
package agu_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_DISP    = 3'd2,
      AM_PREDEC  = 3'd3,
      AM_POSTINC = 3'd4
   } amode_e;

   localparam int PTR_X = 0;
   localparam int PTR_Y = 1;
   localparam int PTR_Z = 2;

endpackage

// File: rtl/agu_ptr_select.sv
module agu_ptr_select #(
   parameter int DATA_W    = 8,
   parameter int NUM_PTR   = 3,
   parameter int PTR_SEL_W = 2,
   parameter logic [NUM_PTR-1:0] DISP_OK_MASK = 3'b110,
   localparam int PTR_W    = 2 * DATA_W,
   localparam int BYTES_W  = PTR_W * NUM_PTR
) (
   input  logic [BYTES_W-1:0]   bytes_i,
   input  logic [PTR_SEL_W-1:0] sel_i,
   output logic [PTR_W-1:0]     ptr_o,
   output logic                 sel_ok_o,
   output logic                 disp_ok_o
);

   logic [PTR_W-1:0] pair [NUM_PTR];

   for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
      localparam int LO = 2 * g * DATA_W;
      assign pair[g] = {bytes_i[LO+DATA_W +: DATA_W], bytes_i[LO +: DATA_W]};
   end

   always_comb begin
      ptr_o     = '0;
      sel_ok_o  = 1'b0;
      disp_ok_o = 1'b0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (sel_i == PTR_SEL_W'(i)) begin
            ptr_o     = pair[i];
            sel_ok_o  = 1'b1;
            disp_ok_o = DISP_OK_MASK[i];
         end
      end
   end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
   import agu_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 6
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic              sel_ok_i,
   input  logic              disp_ok_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [ADDR_W-1:0] direct_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              wb_o,
   output logic [ADDR_W-1:0] wb_val_o,
   output logic              illegal_o
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] ptr_dec;
   logic [ADDR_W-1:0] ptr_inc;

   assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp_i};
   assign ptr_dec  = ptr_i - ONE;
   assign ptr_inc  = ptr_i + ONE;

   always_comb begin
      ea_o      = '0;
      wb_o      = 1'b0;
      wb_val_o  = '0;
      illegal_o = 1'b0;
      case (mode_i)
         AM_DIRECT: ea_o = direct_i;
         AM_IND: begin
            if (sel_ok_i) ea_o = ptr_i;
            else          illegal_o = 1'b1;
         end
         AM_DISP: begin
            if (sel_ok_i && disp_ok_i) ea_o = ptr_i + disp_ext;
            else                       illegal_o = 1'b1;
         end
         AM_PREDEC: begin
            if (sel_ok_i) begin
               ea_o     = ptr_dec;
               wb_o     = 1'b1;
               wb_val_o = ptr_dec;
            end else begin
               illegal_o = 1'b1;
            end
         end
         AM_POSTINC: begin
            if (sel_ok_i) begin
               ea_o     = ptr_i;
               wb_o     = 1'b1;
               wb_val_o = ptr_inc;
            end else begin
               illegal_o = 1'b1;
            end
         end
         default: illegal_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
   parameter int ADDR_W    = 16,
   parameter int PTR_SEL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [ADDR_W-1:0]    ea_i,
   input  logic                 wb_i,
   input  logic [PTR_SEL_W-1:0] sel_i,
   input  logic [ADDR_W-1:0]    wb_val_i,
   input  logic                 illegal_i,
   output logic [ADDR_W-1:0]    ea_o,
   output logic                 valid_o,
   output logic                 wb_o,
   output logic [PTR_SEL_W-1:0] wb_sel_o,
   output logic [ADDR_W-1:0]    wb_val_o,
   output logic                 illegal_o
);

   logic take;
   logic take_wb;

   assign take    = req_i && !illegal_i;
   assign take_wb = take && wb_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_o      <= '0;
         valid_o   <= 1'b0;
         wb_o      <= 1'b0;
         wb_sel_o  <= '0;
         wb_val_o  <= '0;
         illegal_o <= 1'b0;
      end else begin
         ea_o      <= take ? ea_i : '0;
         valid_o   <= take;
         wb_o      <= take_wb;
         wb_sel_o  <= take_wb ? sel_i : '0;
         wb_val_o  <= take_wb ? wb_val_i : '0;
         illegal_o <= req_i && illegal_i;
      end
   end

endmodule

// File: rtl/data_ptr_agu.sv
module data_ptr_agu
   import agu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int DISP_W    = 6,
   parameter int NUM_PTR   = 3,
   parameter int PTR_SEL_W = 2,
   parameter logic [NUM_PTR-1:0] DISP_OK_MASK = 3'b110,
   localparam int BYTES_W  = 2 * DATA_W * NUM_PTR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [MODE_W-1:0]    mode,
   input  logic [PTR_SEL_W-1:0] ptr_sel,
   input  logic [DISP_W-1:0]    disp,
   input  logic [ADDR_W-1:0]    direct_addr,
   input  logic [BYTES_W-1:0]   ptr_bytes,
   output logic [ADDR_W-1:0]    ea,
   output logic                 ea_valid,
   output logic                 wb_en,
   output logic [PTR_SEL_W-1:0] wb_sel,
   output logic [ADDR_W-1:0]    wb_value,
   output logic                 illegal
);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("pointer width must be two data bytes");
   end
   if (DISP_W >= ADDR_W) begin : g_bad_disp
      $error("displacement must be narrower than the address");
   end
   if (NUM_PTR > (1 << PTR_SEL_W)) begin : g_bad_sel
      $error("pointer select too narrow for pointer count");
   end

   logic [ADDR_W-1:0] ptr_c;
   logic              sel_ok_c;
   logic              disp_ok_c;
   logic [ADDR_W-1:0] ea_c;
   logic              wb_c;
   logic [ADDR_W-1:0] wb_val_c;
   logic              illegal_c;

   agu_ptr_select #(
      .DATA_W      (DATA_W),
      .NUM_PTR     (NUM_PTR),
      .PTR_SEL_W   (PTR_SEL_W),
      .DISP_OK_MASK(DISP_OK_MASK)
   ) u_sel (
      .bytes_i  (ptr_bytes),
      .sel_i    (ptr_sel),
      .ptr_o    (ptr_c),
      .sel_ok_o (sel_ok_c),
      .disp_ok_o(disp_ok_c)
   );

   agu_addr_calc #(
      .ADDR_W(ADDR_W),
      .DISP_W(DISP_W)
   ) u_calc (
      .mode_i   (mode),
      .ptr_i    (ptr_c),
      .sel_ok_i (sel_ok_c),
      .disp_ok_i(disp_ok_c),
      .disp_i   (disp),
      .direct_i (direct_addr),
      .ea_o     (ea_c),
      .wb_o     (wb_c),
      .wb_val_o (wb_val_c),
      .illegal_o(illegal_c)
   );

   agu_out_stage #(
      .ADDR_W   (ADDR_W),
      .PTR_SEL_W(PTR_SEL_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_valid),
      .ea_i     (ea_c),
      .wb_i     (wb_c),
      .sel_i    (ptr_sel),
      .wb_val_i (wb_val_c),
      .illegal_i(illegal_c),
      .ea_o     (ea),
      .valid_o  (ea_valid),
      .wb_o     (wb_en),
      .wb_sel_o (wb_sel),
      .wb_val_o (wb_value),
      .illegal_o(illegal)
   );

endmodule

// File: rtl/agu_checker.sv
module agu_checker
   import agu_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PTR_SEL_W = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [MODE_W-1:0]    mode,
   input logic [PTR_SEL_W-1:0] ptr_sel,
   input logic [ADDR_W-1:0]    direct_addr,
   input logic [ADDR_W-1:0]    ea,
   input logic                 ea_valid,
   input logic                 wb_en,
   input logic [ADDR_W-1:0]    wb_value,
   input logic                 illegal
);

   assert_direct_ea_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_DIRECT) |=> (ea == $past(direct_addr) && !wb_en));

   assert_no_wb_indirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_IND) |=> !wb_en);

   assert_no_wb_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_DISP) |=> !wb_en);

   assert_x_disp_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_DISP && ptr_sel == PTR_SEL_W'(PTR_X))
      |=> (illegal && !ea_valid && !wb_en));

   assert_predec_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_PREDEC && ptr_sel <= PTR_SEL_W'(PTR_Z))
      |=> (wb_en && wb_value == ea));

   assert_postinc_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == AM_POSTINC && ptr_sel <= PTR_SEL_W'(PTR_Z))
      |=> (wb_en && wb_value == ea + ADDR_W'(1)));

   assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!ea_valid && !wb_en && !illegal));

   assert_flag_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal, ea_valid}) && (!wb_en || ea_valid));

endmodule

bind data_ptr_agu agu_checker #(
   .ADDR_W   (ADDR_W),
   .PTR_SEL_W(PTR_SEL_W)
) u_agu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .mode       (mode),
   .ptr_sel    (ptr_sel),
   .direct_addr(direct_addr),
   .ea         (ea),
   .ea_valid   (ea_valid),
   .wb_en      (wb_en),
   .wb_value   (wb_value),
   .illegal    (illegal)
);

// File: tb/data_ptr_agu_test.sv
module data_ptr_agu_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  ptr_sel = '0;
   logic [5:0]  disp = '0;
   logic [15:0] direct_addr = '0;
   logic [47:0] ptr_bytes = '0;
   logic [15:0] ea;
   logic        ea_valid;
   logic        wb_en;
   logic [1:0]  wb_sel;
   logic [15:0] wb_value;
   logic        illegal;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   data_ptr_agu uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .ptr_sel(ptr_sel), .disp(disp), .direct_addr(direct_addr),
      .ptr_bytes(ptr_bytes), .ea(ea), .ea_valid(ea_valid), .wb_en(wb_en),
      .wb_sel(wb_sel), .wb_value(wb_value), .illegal(illegal)
   );

   // packed result: {illegal, ea_valid, wb_en, wb_sel, ea, wb_value}
   function automatic logic [36:0] model(input logic [2:0] m, input logic [1:0] s,
                                         input logic [15:0] px, input logic [15:0] py,
                                         input logic [15:0] pz, input logic [5:0] d,
                                         input logic [15:0] dir);
      logic [15:0] p;
      logic        ok;
      logic        ill = 1'b0;
      logic        wb = 1'b0;
      logic [15:0] e = '0;
      logic [15:0] v = '0;
      ok = (s != 2'd3);
      p  = (s == 2'd0) ? px : (s == 2'd1) ? py : (s == 2'd2) ? pz : 16'h0;
      case (m)
         3'd0: e = dir;
         3'd1: if (ok) e = p; else ill = 1'b1;
         3'd2: if (s == 2'd1 || s == 2'd2) e = 16'((32'(p) + 32'(d)) % 65536); else ill = 1'b1;
         3'd3: if (ok) begin e = 16'((32'(p) + 65535) % 65536); wb = 1'b1; v = e; end else ill = 1'b1;
         3'd4: if (ok) begin e = p; wb = 1'b1; v = 16'((32'(p) + 1) % 65536); end else ill = 1'b1;
         default: ill = 1'b1;
      endcase
      return {ill, !ill, wb, (wb ? s : 2'd0), e, v};
   endfunction

   task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [36:0] outs();
      return {illegal, ea_valid, wb_en, wb_sel, ea, wb_value};
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] pvals [6];
      logic [5:0]  dvals [4];
      pvals = '{16'h0000, 16'h0001, 16'hFFFF, 16'hFFC1, 16'h1234, 16'h8000};
      dvals = '{6'd0, 6'd1, 6'd62, 6'd63};

      repeat (3) @(posedge clk);
      #1;
      check("R1 in reset", outs(), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 after release", outs(), '0);

      for (int pi = 0; pi < 6; pi++) begin
         for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
               for (int di = 0; di < 4; di++) begin
                  logic [15:0] px, py, pz;
                  string tag;
                  px = pvals[pi];
                  py = pvals[(pi + 1) % 6] ^ 16'h0F00;
                  pz = pvals[(pi + 2) % 6] ^ 16'h005A;
                  if (m == 2 && s == 1) py = pvals[pi];
                  if (m == 2 && s == 2) pz = pvals[pi];
                  @(negedge clk);
                  req_valid   = 1'b1;
                  mode        = 3'(m);
                  ptr_sel     = 2'(s);
                  disp        = dvals[di];
                  direct_addr = pvals[pi] ^ 16'(di * 16'h1111);
                  ptr_bytes   = {pz, py, px};
                  if (m > 4 || (m != 0 && s == 3)) tag = "R10";
                  else if (m == 0) tag = "R2";
                  else if (m == 1) tag = "R3";
                  else if (m == 2 && s == 0) tag = "R5";
                  else if (pi == 0 || pi == 2 || pi == 3) tag = "R8";
                  else if (m == 2) tag = "R4";
                  else if (m == 3) tag = "R6";
                  else tag = "R7";
                  @(posedge clk);
                  #1;
                  check(tag, outs(), model(3'(m), 2'(s), px, py, pz, dvals[di], direct_addr));
               end
            end
         end
         // idle cycle after each burst: outputs must clear (R9)
         @(negedge clk);
         req_valid = 1'b0;
         mode      = 3'd4;
         @(posedge clk);
         #1;
         check("R9 idle", outs(), '0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule